// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the fetch stage and is looked up every cycle with the address of the instruction being fetched. Each entry holds a valid bit, an address tag and a stored target. An entry exists only for a branch that is expected to be taken. When the tag matches, the block offers the stored target as the next fetch address. When there is no match, it offers the sequential address, because a miss means the instruction is either not a branch or not taken.

When a branch or other instruction completes, the pipeline reports it on the resolution port. The report carries the instruction address, the prediction that fetch used (hit flag and predicted address), whether control actually transferred, and the real destination. From this the block sorts the outcome into a penalty class. It also raises a mispredict with the address where fetch must restart, and edits the table:
- a new taken branch is inserted;
- a wrong-direction hit has its entry removed;
- a wrong-target hit has its target rewritten.

The table is direct-mapped. All addresses are word-aligned.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. `res_done`, `mispredict` and `penalty` are all 0.
- R2: A lookup whose index entry is valid with a matching tag sets `pred_hit`=1 and `pred_next_pc` = the stored target, in the same cycle. A resolution in the same cycle changes the table only from the next cycle on.
- R3: A lookup that misses sets `pred_hit`=0 and `pred_next_pc` = `fetch_pc`+4.
- R4: The index is `pc[7:2]` and the tag is `pc[31:8]`. Two addresses with the same index but different tags share one entry, and only the one written last hits.
- R5: A resolved hit that was taken to the predicted address gives penalty 0 and no mispredict, and leaves the entry unchanged.
- R6: A resolved hit that was not taken gives penalty 2, a mispredict, and restart = `res_pc`+4. It removes the entry at that index only when the entry's tag still equals the tag of `res_pc`.
- R7: A resolved miss that was taken gives penalty 2, a mispredict, and restart = `res_target`. It writes `res_pc` with `res_target` into the table.
- R8: A resolved miss that was not taken gives penalty 0 and no mispredict, and leaves the table unchanged.
- R9: A resolved hit that was taken to an address other than the predicted one gives penalty 2, a mispredict, and restart = `res_target`. It overwrites the stored target with `res_target`.
- R10: Results are registered. `res_done` is 1 exactly in the cycle after a cycle with `res_valid`=1. When `res_done`=0, `mispredict`, `restart_pc` and `penalty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Lookup found a predicted-taken branch |
| pred_next_pc | output | 32 | Next fetch address (stored target or sequential) |
| res_valid | input | 1 | A resolution report is present |
| res_pc | input | 32 | Address of the resolved instruction |
| res_pred_hit | input | 1 | Fetch saw a hit for this instruction |
| res_pred_target | input | 32 | Next address fetch used on that hit |
| res_taken | input | 1 | Control actually transferred |
| res_target | input | 32 | Actual destination when taken |
| res_done | output | 1 | Registered result of a resolution is present |
| mispredict | output | 1 | Younger fetched work must be killed |
| restart_pc | output | 32 | Address where fetch restarts |
| penalty | output | 2 | Penalty class in cycles (0 or 2) |

## Verification
The bench targets aliasing, where two addresses share an index. A design that skipped the tag compare or kept both entries would report a hit for the evicted address. It also resolves a stale wrong-direction hit whose entry has since been replaced. A design that removes entries without checking the tag would wipe out the newer branch. Same-target, changed-target and not-taken outcomes on a hit are all exercised. A design that retrains the entry instead of removing it, or restarts at the old target, would show a wrong `restart_pc` or a later lookup that still hits. Lookups made in the same cycle as a table write confirm that the write is seen only one cycle later.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Classification of one resolution report
    typedef enum logic [2:0] {
        RES_NONE,
        RES_HIT_OK,
        RES_HIT_WRONG_DIR,
        RES_HIT_WRONG_TGT,
        RES_MISS_TAKEN,
        RES_MISS_QUIET
    } res_class_e;

    function automatic res_class_e classify(
        input logic valid,
        input logic pred_hit,
        input logic taken,
        input logic tgt_same
    );
        if (!valid)
            return RES_NONE;
        if (pred_hit) begin
            if (!taken)
                return RES_HIT_WRONG_DIR;
            return tgt_same ? RES_HIT_OK : RES_HIT_WRONG_TGT;
        end
        return taken ? RES_MISS_TAKEN : RES_MISS_QUIET;
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    localparam int N     = 1 << IDX_W,
    localparam int TAG_W = PC_W - IDX_W - 2,
    localparam int TGT_W = PC_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup read port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    // resolution check port
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_valid,
    output logic [TAG_W-1:0] chk_tag,
    // write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt
);

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][TGT_W-1:0] tgt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = wr_valid;
            st_d.tag[wr_idx] = wr_tag;
            st_d.tgt[wr_idx] = wr_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_valid  = st_q.vld[rd_idx];
    assign rd_tag    = st_q.tag[rd_idx];
    assign rd_tgt    = st_q.tgt[rd_idx];
    assign chk_valid = st_q.vld[chk_idx];
    assign chk_tag   = st_q.tag[chk_idx];

    // R7: an accepted write is visible at its index on the next cycle
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.vld[$past(wr_idx)] == $past(wr_valid)) &&
                  (!$past(wr_valid) || st_q.tgt[$past(wr_idx)] == $past(wr_tgt)));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    localparam int TAG_W = PC_W - IDX_W - 2,
    localparam int TGT_W = PC_W - 2
) (
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [IDX_W-1:0] idx,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TGT_W-1:0] ent_tgt,
    output logic             hit,
    output logic [PC_W-1:0]  next_pc
);

    logic [TAG_W-1:0] pc_tag;

    always_comb begin
        idx     = fetch_pc[IDX_W+1:2];
        pc_tag  = fetch_pc[PC_W-1:IDX_W+2];
        hit     = ent_valid && (ent_tag == pc_tag);
        next_pc = hit ? {ent_tgt, 2'b00} : fetch_pc + PC_W'(4);
    end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int PEN_W = 2,
    localparam int TAG_W    = PC_W - IDX_W - 2,
    localparam int TGT_W    = PC_W - 2,
    localparam int MISS_PEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_pred_hit,
    input  logic [PC_W-1:0]  res_pred_target,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    // table state at the resolved index
    output logic [IDX_W-1:0] chk_idx,
    input  logic             chk_valid,
    input  logic [TAG_W-1:0] chk_tag,
    // table write
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_valid,
    output logic [TAG_W-1:0] wr_tag,
    output logic [TGT_W-1:0] wr_tgt,
    // registered results
    output logic             done,
    output logic             mispredict,
    output logic [PC_W-1:0]  restart_pc,
    output logic [PEN_W-1:0] penalty
);

    typedef struct packed {
        logic             done;
        logic             mis;
        logic [PC_W-1:0]  restart;
        logic [PEN_W-1:0] pen;
    } out_t;

    out_t       out_d, out_q;
    res_class_e cls;
    logic [TAG_W-1:0] res_tag;

    always_comb begin
        res_tag  = res_pc[PC_W-1:IDX_W+2];
        chk_idx  = res_pc[IDX_W+1:2];
        cls      = classify(res_valid, res_pred_hit, res_taken,
                            res_target == res_pred_target);
        wr_idx   = chk_idx;
        wr_tag   = res_tag;
        wr_tgt   = res_target[PC_W-1:2];
        wr_en    = 1'b0;
        wr_valid = 1'b0;
        out_d    = '0;
        out_d.done = res_valid;
        unique case (cls)
            RES_HIT_WRONG_DIR: begin
                // remove only if the entry still belongs to this branch
                wr_en         = chk_valid && (chk_tag == res_tag);
                wr_valid      = 1'b0;
                out_d.mis     = 1'b1;
                out_d.restart = res_pc + PC_W'(4);
                out_d.pen     = PEN_W'(MISS_PEN);
            end
            RES_HIT_WRONG_TGT, RES_MISS_TAKEN: begin
                wr_en         = 1'b1;
                wr_valid      = 1'b1;
                out_d.mis     = 1'b1;
                out_d.restart = res_target;
                out_d.pen     = PEN_W'(MISS_PEN);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign done       = out_q.done;
    assign mispredict = out_q.mis;
    assign restart_pc = out_q.restart;
    assign penalty    = out_q.pen;

    // R10: a result appears only in the cycle after a report
    p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_valid));
    // R10: idle outputs are zero
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !mispredict && penalty == '0 && restart_pc == '0);
    // R5: correct taken hit costs nothing
    p_hit_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pred_hit && res_taken && res_target == res_pred_target)
        |=> done && !mispredict && penalty == '0);
    // R8: quiet miss costs nothing and writes nothing
    p_quiet_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_pred_hit && !res_taken) |-> !wr_en);
    // R6: wrong direction restarts on the fall-through
    p_wrong_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pred_hit && !res_taken)
        |=> mispredict && restart_pc == $past(res_pc) + PC_W'(4));

endmodule

// File: rtl/btb_top.sv
module btb_top #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int PEN_W = 2,
    localparam int TAG_W = PC_W - IDX_W - 2,
    localparam int TGT_W = PC_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_hit,
    output logic [PC_W-1:0]  pred_next_pc,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_pred_hit,
    input  logic [PC_W-1:0]  res_pred_target,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    output logic             res_done,
    output logic             mispredict,
    output logic [PC_W-1:0]  restart_pc,
    output logic [PEN_W-1:0] penalty
);

    logic [IDX_W-1:0] rd_idx, chk_idx, wr_idx;
    logic             rd_valid, chk_valid, wr_en, wr_valid;
    logic [TAG_W-1:0] rd_tag, chk_tag, wr_tag;
    logic [TGT_W-1:0] rd_tgt, wr_tgt;

    btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
        .fetch_pc  (fetch_pc),
        .idx       (rd_idx),
        .ent_valid (rd_valid),
        .ent_tag   (rd_tag),
        .ent_tgt   (rd_tgt),
        .hit       (pred_hit),
        .next_pc   (pred_next_pc)
    );

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_tgt    (rd_tgt),
        .chk_idx   (chk_idx),
        .chk_valid (chk_valid),
        .chk_tag   (chk_tag),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_tag    (wr_tag),
        .wr_tgt    (wr_tgt)
    );

    btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W), .PEN_W(PEN_W)) u_resolve (
        .clk             (clk),
        .rst_n           (rst_n),
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_pred_hit    (res_pred_hit),
        .res_pred_target (res_pred_target),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .chk_idx         (chk_idx),
        .chk_valid       (chk_valid),
        .chk_tag         (chk_tag),
        .wr_en           (wr_en),
        .wr_idx          (wr_idx),
        .wr_valid        (wr_valid),
        .wr_tag          (wr_tag),
        .wr_tgt          (wr_tgt),
        .done            (res_done),
        .mispredict      (mispredict),
        .restart_pc      (restart_pc),
        .penalty         (penalty)
    );

    // R7: an inserted taken branch hits when looked up right after
    p_insert_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_pred_hit && res_taken && fetch_pc == res_pc)
        |=> (fetch_pc != $past(res_pc)) || pred_hit);

endmodule

// File: tb/btb_top_tb.sv
module btb_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_pred_hit = 1'b0;
    logic [31:0] res_pred_target = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_done, mispredict;
    logic [31:0] restart_pc;
    logic [1:0]  penalty;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference table
    logic        m_vld [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];

    always #5 clk = ~clk;

    btb_top u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_pred_hit(res_pred_hit),
        .res_pred_target(res_pred_target), .res_taken(res_taken),
        .res_target(res_target), .res_done(res_done), .mispredict(mispredict),
        .restart_pc(restart_pc), .penalty(penalty)
    );

    function automatic logic m_hit(input logic [31:0] pc);
        return m_vld[pc[7:2]] && m_tag[pc[7:2]] == pc[31:8];
    endfunction

    function automatic logic [31:0] m_next(input logic [31:0] pc);
        return m_hit(pc) ? m_tgt[pc[7:2]] : pc + 32'd4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_lookup(input logic [31:0] pc, input string req);
        fetch_pc = pc;
        #1;
        chk(pred_hit == m_hit(pc), req, {31'd0, pred_hit}, {31'd0, m_hit(pc)});
        chk(pred_next_pc == m_next(pc), req, pred_next_pc, m_next(pc));
    endtask

    // one resolution; lookup of the same pc is checked in the same cycle
    task automatic resolve(input logic [31:0] pc, input logic phit,
                           input logic [31:0] ptgt, input logic tk,
                           input logic [31:0] tgt, input string req);
        logic        e_mis;
        logic [31:0] e_rst;
        logic [1:0]  e_pen;
        logic [5:0]  ix;
        ix = pc[7:2];
        res_valid = 1'b1; res_pc = pc; res_pred_hit = phit;
        res_pred_target = ptgt; res_taken = tk; res_target = tgt;
        check_lookup(pc, "R2");  // old contents during the write cycle
        e_mis = 1'b0; e_rst = '0; e_pen = 2'd0;
        if (phit && !tk) begin
            e_mis = 1'b1; e_rst = pc + 32'd4; e_pen = 2'd2;
            if (m_vld[ix] && m_tag[ix] == pc[31:8]) m_vld[ix] = 1'b0;
        end else if (tk && (!phit || tgt != ptgt)) begin
            e_mis = 1'b1; e_rst = tgt; e_pen = 2'd2;
            m_vld[ix] = 1'b1; m_tag[ix] = pc[31:8]; m_tgt[ix] = tgt;
        end
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        chk(res_done == 1'b1, "R10", {31'd0, res_done}, 32'd1);
        chk(mispredict == e_mis, req, {31'd0, mispredict}, {31'd0, e_mis});
        chk(restart_pc == e_rst, req, restart_pc, e_rst);
        chk(penalty == e_pen, req, {30'd0, penalty}, {30'd0, e_pen});
    endtask

    logic [31:0] pool [8];
    logic [31:0] tpool [4];

    initial begin
        for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
        // 0x1000 and 0x2000 alias at index 0; 0x1104/0x3104 alias at index 1
        pool[0] = 32'h0000_1000; pool[1] = 32'h0000_2000;
        pool[2] = 32'h0000_1104; pool[3] = 32'h0000_3104;
        pool[4] = 32'h0000_40FC; pool[5] = 32'h0000_5010;
        pool[6] = 32'h0000_6020; pool[7] = 32'h0000_7FF8;
        tpool[0] = 32'h0000_8000; tpool[1] = 32'h0000_8400;
        tpool[2] = 32'h0001_0000; tpool[3] = 32'hFFFF_FFF0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(res_done == 0 && mispredict == 0 && penalty == 0, "R1",
            {30'd0, penalty}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) check_lookup(pool[i], "R1");
        chk(res_done == 0, "R10", {31'd0, res_done}, 32'd0);

        // R7: miss taken inserts; R2: later hit
        resolve(pool[0], 0, pool[0] + 4, 1, tpool[0], "R7");
        check_lookup(pool[0], "R2");
        chk(pred_hit == 1, "R7", {31'd0, pred_hit}, 32'd1);
        // R10: idle cycle after result
        @(negedge clk);
        chk(res_done == 0 && mispredict == 0 && restart_pc == 0, "R10",
            restart_pc, 32'd0);
        // R5: correct hit
        resolve(pool[0], 1, tpool[0], 1, tpool[0], "R5");
        check_lookup(pool[0], "R5");
        // R9: hit taken elsewhere
        resolve(pool[0], 1, tpool[0], 1, tpool[1], "R9");
        check_lookup(pool[0], "R9");
        // R4: alias evicts
        resolve(pool[1], 0, pool[1] + 4, 1, tpool[2], "R4");
        check_lookup(pool[0], "R4");
        check_lookup(pool[1], "R4");
        // R6: stale wrong-direction report must not remove the newer alias
        resolve(pool[0], 1, tpool[1], 0, 32'd0, "R6");
        check_lookup(pool[1], "R6");
        chk(pred_hit == 1, "R6", {31'd0, pred_hit}, 32'd1);
        // R6: real wrong direction removes
        resolve(pool[1], 1, tpool[2], 0, 32'd0, "R6");
        check_lookup(pool[1], "R6");
        chk(pred_hit == 0, "R6", {31'd0, pred_hit}, 32'd0);
        // R8: quiet miss leaves table alone
        resolve(pool[4], 0, pool[4] + 4, 0, 32'd0, "R8");
        check_lookup(pool[4], "R8");
        // R3: sequential on miss at top of an index range
        check_lookup(pool[7], "R3");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] pc, tgt;
            logic        h, tk;
            pc  = pool[$urandom % 8];
            h   = m_hit(pc);
            tk  = ($urandom % 3) != 0;
            tgt = (h && ($urandom % 2)) ? m_next(pc) : tpool[$urandom % 4];
            resolve(pc, h, m_next(pc), tk, tgt,
                    !h ? (tk ? "R7" : "R8") : (!tk ? "R6" : (tgt == m_next(pc) ? "R5" : "R9")));
            if ($urandom % 4 == 0) check_lookup(pool[$urandom % 8], "R3");
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule